// File: doc/BRIEF.md
# Dual-Channel Serial ADC Readout Controller

This controller sits on the host side of a three-wire serial 8-bit converter that picks its input channel from the number of pulses on its convert strobe. A request carries a channel number (0 or 1). The controller raises the strobe once for channel 0, or twice with a low gap for channel 1. After the final falling edge it waits out the converter's internal conversion time. It then clocks out eight bits on a serial clock and returns the assembled byte together with the channel and a one-cycle valid flag.

All timing counts come from the system clock frequency parameter. Each count is rounded up, so the minimum strobe width, the minimum conversion wait and the maximum serial clock rate always hold. The sequence runs as one state machine. `ST_IDLE` goes to `ST_STROBE_HI` on an accepted request. `ST_STROBE_HI` goes to `ST_STROBE_GAP` when a second pulse is still due, and otherwise to `ST_CONVERT`. `ST_STROBE_GAP` returns to `ST_STROBE_HI`. `ST_CONVERT` goes to `ST_SCK_LO`. `ST_SCK_LO` goes to `ST_SCK_HI`, and the data line is sampled on that transition. `ST_SCK_HI` goes back to `ST_SCK_LO` until eight bits are held, and then to `ST_FINISH`. `ST_FINISH` goes to `ST_IDLE`. Each timed state lasts for a count loaded into a shared down-counter.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `adc_cnv`, `adc_sclk`, `result_valid` and `busy` are all low until a request is accepted.
- R2: A request with `ch_sel` = 0 produces exactly one high pulse on `adc_cnv`, and the strobe is high in the cycle after the request is sampled.
- R3: A request with `ch_sel` = 1 produces exactly two high pulses on `adc_cnv`, separated by a low interval.
- R4: Every high pulse of `adc_cnv`, and the low gap between the two pulses for channel 1, lasts at least `STROBE_MIN_NS` (50 ns by default).
- R5: The first rising edge of `adc_sclk` comes no earlier than `CONV_MIN_NS` (7.5 µs by default) after the last falling edge of `adc_cnv`.
- R6: `adc_sclk` idles low. Each of its high and low phases lasts at least half of one period at `SCLK_MAX_HZ` (100 ns at 5 MHz). It produces exactly eight rising edges per request.
- R7: `adc_sdata` is sampled at each rising edge of `adc_sclk`. The first sampled bit lands in bit 7 of `result_data` and the last in bit 0 (straight binary, MSB first).
- R8: `result_valid` is high for exactly one cycle per request. In that cycle, `result_ch` equals the requested channel and `result_data` holds the byte.
- R9: A `start` raised while `busy` is high is ignored: it adds no strobe pulses and yields no extra result.
- R10: `busy` is high from the cycle after a request is accepted through the cycle in which `result_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, accepted only when idle |
| ch_sel | input | 1 | Channel of the request (0 or 1) |
| busy | output | 1 | A request is in progress |
| adc_cnv | output | 1 | Convert strobe to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| adc_sdata | input | 1 | Serial data from the converter |
| result_data | output | DATA_W | Assembled result byte |
| result_ch | output | 1 | Channel of the result |
| result_valid | output | 1 | One-cycle result strobe |

## Verification
On every cycle, the assertions check these properties:
- the valid flag is a single-cycle pulse that only occurs once the shift register holds all bits;
- the serial clock stays low while idle and never overlaps the strobe;
- the latched channel cannot change under an ignored request;
- the bit counter never passes the word width.

Only the bench scenarios can show the properties measured in time or counted over a whole request. These are the pulse count per channel, the strobe and gap widths, the conversion wait, the serial clock phase lengths and the bit order of the returned byte. The bench checks them against a model of the converter that chooses its channel from the strobe edges it sees.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE_HI,
        ST_STROBE_GAP,
        ST_CONVERT,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_FINISH
    } rd_state_e;

    // Cycles covering at least dur_ns at clk_hz, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                                 longint unsigned dur_ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = clk_hz * dur_ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

    // Half-period in cycles so that the serial clock stays at or below max_hz.
    function automatic int unsigned half_period_cycles(longint unsigned clk_hz,
                                                       longint unsigned max_hz);
        longint unsigned den;
        longint unsigned cyc;
        den = 2 * max_hz;
        cyc = (clk_hz + den - 1) / den;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    // A load of N keeps the owning state for exactly N cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val - 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    // A load value of zero would wrap the counter to its maximum.
    p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             sdata,
    output logic [WIDTH-1:0] data,
    output logic             full
);

    localparam int BCNT_W = $clog2(WIDTH + 1);

    logic [BCNT_W-1:0] nbits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            nbits <= '0;
        end else if (clear) begin
            data  <= '0;
            nbits <= '0;
        end else if (sample && !full) begin
            data  <= {data[WIDTH-2:0], sdata};
            nbits <= nbits + 1'b1;
        end
    end

    assign full = (nbits == BCNT_W'(WIDTH));

    p_bitcount_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= BCNT_W'(WIDTH));

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 50_000_000,
    parameter longint unsigned SCLK_MAX_HZ   = 5_000_000,
    parameter longint unsigned STROBE_MIN_NS = 50,
    parameter longint unsigned CONV_MIN_NS   = 7_500,
    parameter int              DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ch_sel,
    output logic              busy,
    output logic              adc_cnv,
    output logic              adc_sclk,
    input  logic              adc_sdata,
    output logic [DATA_W-1:0] result_data,
    output logic              result_ch,
    output logic              result_valid
);

    localparam int unsigned STROBE_CYC = ns_to_cycles(CLK_HZ, STROBE_MIN_NS);
    localparam int unsigned CONV_CYC   = ns_to_cycles(CLK_HZ, CONV_MIN_NS);
    localparam int unsigned HALF_CYC   = half_period_cycles(CLK_HZ, SCLK_MAX_HZ);
    localparam int unsigned MAX_A      = (STROBE_CYC > HALF_CYC) ? STROBE_CYC : HALF_CYC;
    localparam int unsigned MAX_CYC    = (CONV_CYC > MAX_A) ? CONV_CYC : MAX_A;
    localparam int          CNT_W      = $clog2(MAX_CYC + 1);

    rd_state_e        state, next_state;
    logic             ch_q;
    logic             second_done;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_expired;
    logic             sh_clear;
    logic             sh_sample;
    logic             sh_full;

    adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    adc_rd_shift #(.WIDTH(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sh_clear),
        .sample (sh_sample),
        .sdata  (adc_sdata),
        .data   (result_data),
        .full   (sh_full)
    );

    // Transition logic and timer loads
    always_comb begin
        next_state = state;
        t_load     = 1'b0;
        t_val      = '0;
        sh_clear   = 1'b0;
        sh_sample  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    next_state = ST_STROBE_HI;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(STROBE_CYC);
                    sh_clear   = 1'b1;
                end
            end
            ST_STROBE_HI: begin
                if (t_expired) begin
                    t_load = 1'b1;
                    if (ch_q && !second_done) begin
                        next_state = ST_STROBE_GAP;
                        t_val      = CNT_W'(STROBE_CYC);
                    end else begin
                        next_state = ST_CONVERT;
                        t_val      = CNT_W'(CONV_CYC);
                    end
                end
            end
            ST_STROBE_GAP: begin
                if (t_expired) begin
                    next_state = ST_STROBE_HI;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(STROBE_CYC);
                end
            end
            ST_CONVERT: begin
                if (t_expired) begin
                    next_state = ST_SCK_LO;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(HALF_CYC);
                end
            end
            ST_SCK_LO: begin
                if (t_expired) begin
                    next_state = ST_SCK_HI;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(HALF_CYC);
                    sh_sample  = 1'b1;
                end
            end
            ST_SCK_HI: begin
                if (t_expired) begin
                    if (sh_full) begin
                        next_state = ST_FINISH;
                    end else begin
                        next_state = ST_SCK_LO;
                        t_load     = 1'b1;
                        t_val      = CNT_W'(HALF_CYC);
                    end
                end
            end
            ST_FINISH: begin
                next_state = ST_IDLE;
            end
            default: begin
                next_state = ST_IDLE;
            end
        endcase
    end

    // State register with per-request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ch_q        <= 1'b0;
            second_done <= 1'b0;
        end else begin
            state <= next_state;
            if (state == ST_IDLE) begin
                second_done <= 1'b0;
                if (start) ch_q <= ch_sel;
            end else if (state == ST_STROBE_GAP && t_expired) begin
                second_done <= 1'b1;
            end
        end
    end

    // Registered outputs decoded from the next state, glitch-free at the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_cnv      <= 1'b0;
            adc_sclk     <= 1'b0;
            busy         <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            adc_cnv      <= (next_state == ST_STROBE_HI);
            adc_sclk     <= (next_state == ST_SCK_HI);
            busy         <= (next_state != ST_IDLE);
            result_valid <= (next_state == ST_FINISH);
        end
    end

    assign result_ch = ch_q;

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_valid_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> sh_full);

    p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !adc_sclk);

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cnv);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(ch_q));

endmodule

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;

    localparam int  CLK_PERIOD = 20;
    localparam real STROBE_NS  = 50.0;
    localparam real CONV_NS    = 7500.0;
    localparam real HALF_NS    = 100.0;
    localparam int  WATCHDOG   = 150_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ch_sel = 1'b0;
    logic       busy, adc_cnv, adc_sclk, result_ch, result_valid;
    logic       adc_sdata = 1'b0;
    logic [7:0] result_data;

    adc_rd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_sel(ch_sel),
        .busy(busy), .adc_cnv(adc_cnv), .adc_sclk(adc_sclk),
        .adc_sdata(adc_sdata), .result_data(result_data),
        .result_ch(result_ch), .result_valid(result_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int results_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Converter model: channel chosen by the number of strobe falls
    logic [7:0] chan_val [2];
    logic [7:0] cur_word = 8'h00;
    int  cnv_falls = 0;
    int  bit_idx = 0;
    int  cnv_rises = 0;
    int  sck_rises = 0;
    real t_cnv_rise = 0.0;
    real t_cnv_fall = 0.0;
    real t_sck_rise = 0.0;
    real t_sck_fall = 0.0;
    bit  armed = 1'b0;

    always @(posedge adc_cnv) begin
        if (armed) begin
            if (cnv_rises > 0)
                chk(($realtime - t_cnv_fall) >= STROBE_NS, "R4", "gap_ns",
                    longint'($realtime - t_cnv_fall), longint'(STROBE_NS));
            cnv_rises++;
            t_cnv_rise = $realtime;
        end
    end

    always @(negedge adc_cnv) begin
        if (armed && cnv_rises > 0) begin
            chk(($realtime - t_cnv_rise) >= STROBE_NS, "R4", "high_ns",
                longint'($realtime - t_cnv_rise), longint'(STROBE_NS));
            cnv_falls++;
            t_cnv_fall = $realtime;
            cur_word  = (cnv_falls >= 2) ? chan_val[1] : chan_val[0];
            bit_idx   = 7;
            adc_sdata = cur_word[7];
        end
    end

    always @(posedge adc_sclk) begin
        if (armed) begin
            if (sck_rises == 0)
                chk(($realtime - t_cnv_fall) >= CONV_NS, "R5", "conv_wait_ns",
                    longint'($realtime - t_cnv_fall), longint'(CONV_NS));
            else
                chk(($realtime - t_sck_fall) >= HALF_NS, "R6", "sclk_low_ns",
                    longint'($realtime - t_sck_fall), longint'(HALF_NS));
            sck_rises++;
            t_sck_rise = $realtime;
        end
    end

    always @(negedge adc_sclk) begin
        if (armed && sck_rises > 0) begin
            chk(($realtime - t_sck_rise) >= HALF_NS, "R6", "sclk_high_ns",
                longint'($realtime - t_sck_rise), longint'(HALF_NS));
            t_sck_fall = $realtime;
            if (bit_idx > 0) begin
                bit_idx--;
                adc_sdata = cur_word[bit_idx];
            end
        end
    end

    // Scoreboard
    typedef struct {
        logic       ch;
        logic [7:0] data;
    } exp_t;
    exp_t exp_q[$];
    bit   prev_valid = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid)
                chk(!result_valid, "R8", "valid_len", result_valid, 0);
            if (result_valid) begin
                results_seen++;
                chk(busy, "R10", "busy_at_valid", busy, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected_result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result_data == e.data, "R7", "data", result_data, e.data);
                    chk(result_ch == e.ch, "R8", "channel", result_ch, e.ch);
                    chk(cnv_rises == (e.ch ? 2 : 1), e.ch ? "R3" : "R2",
                        "strobe_pulses", cnv_rises, e.ch ? 2 : 1);
                    chk(sck_rises == 8, "R6", "sclk_rises", sck_rises, 8);
                end
            end
            prev_valid = result_valid;
        end
    end

    task automatic request(input logic ch, input logic [7:0] val, input bit poke_busy);
        exp_t e;
        while (busy) @(negedge clk);
        chan_val[ch]  = val;
        chan_val[!ch] = ~val;
        cnv_rises = 0;
        cnv_falls = 0;
        sck_rises = 0;
        armed = 1'b1;
        e.ch = ch;
        e.data = val;
        exp_q.push_back(e);
        start  = 1'b1;
        ch_sel = ch;
        @(negedge clk);
        start  = 1'b0;
        chk(busy, "R10", "busy_after_start", busy, 1);
        chk(adc_cnv, "R2", "strobe_after_start", adc_cnv, 1);
        if (poke_busy) begin
            repeat (60) @(negedge clk);
            start  = 1'b1;
            ch_sel = !ch;
            @(negedge clk);
            start  = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(!busy && !adc_sclk && !adc_cnv, "R10", "idle_after_result",
            {busy, adc_sclk, adc_cnv}, 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        chk(1'b0, "R1", "watchdog_expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        chan_val[0] = 8'h00;
        chan_val[1] = 8'h00;
        repeat (3) @(negedge clk);
        chk({adc_cnv, adc_sclk, result_valid, busy} == 4'b0, "R1", "in_reset",
            {adc_cnv, adc_sclk, result_valid, busy}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({adc_cnv, adc_sclk, result_valid, busy} == 4'b0, "R1", "after_reset",
            {adc_cnv, adc_sclk, result_valid, busy}, 0);

        request(1'b0, 8'hA5, 1'b0);
        request(1'b1, 8'h5A, 1'b0);
        request(1'b0, 8'h00, 1'b0);
        request(1'b1, 8'hFF, 1'b0);
        request(1'b0, 8'h80, 1'b0);
        request(1'b1, 8'h01, 1'b0);
        request(1'b0, 8'h3C, 1'b1);   // R9: start during conversion
        request(1'b1, 8'hC3, 1'b1);   // R9: start during conversion
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "pending_results", exp_q.size(), 0);
        chk(results_seen == 8, "R9", "result_count", results_seen, 8);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule